// File: doc/BRIEF.md
# Age-Weighted Packet Output Arbiter

This block decides which waiting packet may use one router output next. Seven input sources each offer four virtual channels, which gives 28 requesters. A requester keeps the output from the moment it is granted until its last flit has passed. Only then does arbitration run again. Each grant is decided by one of two policies. Round-robin rotates fairly over the requesters. Age-first picks the packet that has waited longest. A 64-bit policy mask, indexed by a running grant counter, chooses the policy for each grant.

The block also keeps the age of every waiting packet. When a packet arrives, its age is the incoming age plus a per-hop bias. Packets on the two lower virtual channels receive the request bias, and packets on the two upper ones receive the response bias. A programmable countdown timer then adds one to the age of every packet still waiting at each expiry. All ages stop at 255. The age of the granted packet is driven out, so that it travels on with the packet.

Top module: `age_output_arbiter`

## Requirements
- R1: Once a requester is granted, `gnt_vec` stays unchanged until `pkt_done` is sampled high. The edge that samples it removes the grant. The output is then idle for at least one cycle before the next grant.
- R2: Requester index r is source*4 + vc. `gnt_vec` is one-hot or zero, and `gnt_active` is high exactly when it is nonzero. A request raised before edge k is taken in at edge k. If the output is free, it can be granted at edge k+1. A request is dropped when `req_vec[r]` is low.
- R3: Under round-robin, the winner is the first waiting requester found by scanning upward from the round-robin pointer and wrapping from 27 to 0.
- R4: Under age-first, the waiting requester with the largest age wins. A tie goes to the tied requester that is reached first when scanning upward from the age pointer with wrap.
- R5: After a grant, only the pointer of the policy that was used moves, to one past the winner (27 wraps to 0). The other pointer is left unchanged.
- R6: A 6-bit grant counter, which is 0 after reset, steps by one on every grant and wraps from 63 to 0. Bit `cfg_policy_mask[counter]` selects the policy: 0 is round-robin and 1 is age-first.
- R7: On arrival, a packet's age is `req_age` plus `cfg_req_bias` when vc is 0 or 1, or plus `cfg_rsp_bias` when vc is 2 or 3. `gnt_age` shows the age of the granted packet.
- R8: Every age addition saturates at 255.
- R9: The timer pulses `age_tick` in the first cycle after reset and then every `cfg_timer_period`+1 cycles, reloading from the period at each pulse. Each pulse adds one to the age of every waiting packet that is not granted. The granted packet's age is frozen.
- R10: Reset clears every grant, both pointers, the grant counter and all stored packets, so `gnt_active` is 0 and `gnt_age` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_policy_mask | input | 64 | Per-grant policy bits (1 = age-first) |
| cfg_timer_period | input | 32 | Reload value of the ageing countdown |
| cfg_req_bias | input | 8 | Hop bias for virtual channels 0 and 1 |
| cfg_rsp_bias | input | 8 | Hop bias for virtual channels 2 and 3 |
| req_vec | input | 28 | Packet waiting, per requester |
| req_age | input | 224 | Incoming age per requester, 8 bits each, requester r at bits 8r+7..8r |
| pkt_done | input | 1 | Tail flit of the granted packet passes this cycle |
| gnt_vec | output | 28 | One-hot grant |
| gnt_active | output | 1 | Output owned by a packet |
| gnt_age | output | 8 | Current age of the granted packet |
| gnt_by_age | output | 1 | The current grant was decided by age |
| age_tick | output | 1 | Ageing timer expiry pulse |

## Verification
The bench checks age ties in two ways. The first case breaks a tie from pointer 0. The second breaks it from a pointer left mid-range by an earlier grant, with the winner lying after the wrap. A design that scanned from a fixed index would pick the wrong requester in at least one of them. It then alternates policies through a sparse mask and checks that the round-robin pointer still holds its old value after several age grants. A design that shared one pointer, or moved both, would grant out of order. The bench also drives 64 grants, so the counter wraps back to mask bit 0, which flips that decision from round-robin to age. For ageing, it counts the timer pulses a blocked packet sees and compares them with the reported age. This catches a granted packet that keeps ageing, a tick lost on the arrival edge, and a wrong reload interval. A 250-age arrival with bias checks saturation.

// File: rtl/arb_pkg.sv
// Shared age type and saturating arithmetic for the output arbiter.
// Assumes packet ages are unsigned 8-bit values.
package arb_pkg;
    localparam int AGE_W = 8;
    typedef logic [AGE_W-1:0] age_t;

    // Unsigned add that clamps at the largest age
    function automatic age_t sat_add(input age_t a, input age_t b);
        logic [AGE_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[AGE_W] ? {AGE_W{1'b1}} : s[AGE_W-1:0];
    endfunction
endpackage

// File: rtl/age_tick_timer.sv
// Free-running countdown that pulses once per expiry and reloads.
// Assumes the period may change at any time; it takes effect at the next reload.
module age_tick_timer #(
    parameter int TIMER_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIMER_W-1:0] period,
    output logic               tick
);
    logic [TIMER_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Count down, reload from the period at zero
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= period;
        else           cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/age_book.sv
// Holds one waiting packet per requester together with its age.
// An arriving packet gets its incoming age plus the bias of its VC class;
// waiting, ungranted packets gain one per timer tick. Assumes a requester
// keeps its request high until its packet has been completed.
module age_book
    import arb_pkg::*;
#(
    parameter int NREQ   = 28,
    parameter int NUM_VC = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NREQ-1:0]       req_vec,
    input  logic [NREQ*AGE_W-1:0] age_in,
    input  age_t                  req_bias,
    input  age_t                  rsp_bias,
    input  logic                  tick,
    input  logic [NREQ-1:0]       gnt_vec,
    input  logic                  pkt_done,
    output logic [NREQ-1:0]       occ,
    output logic [NREQ*AGE_W-1:0] age_flat
);
    for (genvar r = 0; r < NREQ; r++) begin : g_slot
        localparam int VC = r % NUM_VC;
        age_t bias;
        age_t age_q;
        logic occ_q;

        if (VC < NUM_VC / 2) begin : g_reqcls
            assign bias = req_bias;
        end else begin : g_rspcls
            assign bias = rsp_bias;
        end

        // Track arrival, completion and ageing of this requester's packet
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q <= 1'b0;
                age_q <= '0;
            end else if (!req_vec[r] || (pkt_done && gnt_vec[r])) begin
                occ_q <= 1'b0;
            end else if (!occ_q) begin
                occ_q <= 1'b1;
                age_q <= sat_add(age_t'(age_in[r*AGE_W +: AGE_W]), bias);
            end else if (tick && !gnt_vec[r]) begin
                age_q <= sat_add(age_q, age_t'(1));
            end
        end

        assign occ[r]                   = occ_q;
        assign age_flat[r*AGE_W +: AGE_W] = age_q;
    end
endmodule

// File: rtl/rot_picker.sv
// Scans candidates upward from a rotating pointer with wrap. BY_AGE=0 takes
// the first candidate; BY_AGE=1 takes the largest age, first in scan order on ties.
// Assumes ptr < NREQ.
module rot_picker
    import arb_pkg::*;
#(
    parameter int NREQ   = 28,
    parameter bit BY_AGE = 1'b0,
    localparam int IDX_W = $clog2(NREQ)
) (
    input  logic [NREQ-1:0]       cand,
    input  logic [NREQ*AGE_W-1:0] age_flat,
    input  logic [IDX_W-1:0]      ptr,
    output logic                  found,
    output logic [IDX_W-1:0]      win
);
    age_t ages [NREQ];

    for (genvar r = 0; r < NREQ; r++) begin : g_unpack
        assign ages[r] = age_flat[r*AGE_W +: AGE_W];
    end

    if (BY_AGE) begin : g_oldest
        // Largest age wins; strict compare keeps the earliest in scan order
        always_comb begin
            int   idx;
            age_t best;
            found = 1'b0;
            best  = '0;
            win   = '0;
            idx   = 0;
            for (int k = 0; k < NREQ; k++) begin
                idx = int'(ptr) + k;
                if (idx >= NREQ) idx = idx - NREQ;
                if (cand[idx] && (!found || ages[idx] > best)) begin
                    found = 1'b1;
                    best  = ages[idx];
                    win   = IDX_W'(idx);
                end
            end
        end
    end else begin : g_rotate
        // First candidate after the pointer wins
        always_comb begin
            int idx;
            found = 1'b0;
            win   = '0;
            idx   = 0;
            for (int k = 0; k < NREQ; k++) begin
                idx = int'(ptr) + k;
                if (idx >= NREQ) idx = idx - NREQ;
                if (cand[idx] && !found) begin
                    found = 1'b1;
                    win   = IDX_W'(idx);
                end
            end
        end
    end
endmodule

// File: rtl/age_output_arbiter.sv
// One output port's packet arbiter over NUM_SRC sources x NUM_VC channels.
// A policy mask bit, picked by a wrapping grant counter, selects round-robin
// or age-first for each grant; each policy keeps its own pointer. The grant
// is held until pkt_done. Assumes MASK_W is a power of two.
module age_output_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter int NUM_VC  = 4,
    parameter int MASK_W  = 64,
    parameter int TIMER_W = 32,
    localparam int NREQ   = NUM_SRC * NUM_VC,
    localparam int IDX_W  = $clog2(NREQ),
    localparam int CNT_W  = $clog2(MASK_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MASK_W-1:0]     cfg_policy_mask,
    input  logic [TIMER_W-1:0]    cfg_timer_period,
    input  logic [AGE_W-1:0]      cfg_req_bias,
    input  logic [AGE_W-1:0]      cfg_rsp_bias,
    input  logic [NREQ-1:0]       req_vec,
    input  logic [NREQ*AGE_W-1:0] req_age,
    input  logic                  pkt_done,
    output logic [NREQ-1:0]       gnt_vec,
    output logic                  gnt_active,
    output logic [AGE_W-1:0]      gnt_age,
    output logic                  gnt_by_age,
    output logic                  age_tick
);
    logic [NREQ-1:0]       occ;
    logic [NREQ*AGE_W-1:0] age_flat;
    logic                  busy_q;
    logic [NREQ-1:0]       gnt_q;
    logic [IDX_W-1:0]      gnt_idx_q;
    logic                  by_age_q;
    logic [CNT_W-1:0]      gcnt_q;
    logic [IDX_W-1:0]      rr_ptr_q;
    logic [IDX_W-1:0]      age_ptr_q;
    logic                  rr_found, age_found, use_age, found;
    logic [IDX_W-1:0]      rr_win, age_win, win;

    age_tick_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_timer_period),
        .tick   (age_tick)
    );

    age_book #(.NREQ(NREQ), .NUM_VC(NUM_VC)) u_book (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vec  (req_vec),
        .age_in   (req_age),
        .req_bias (cfg_req_bias),
        .rsp_bias (cfg_rsp_bias),
        .tick     (age_tick),
        .gnt_vec  (gnt_q),
        .pkt_done (pkt_done),
        .occ      (occ),
        .age_flat (age_flat)
    );

    rot_picker #(.NREQ(NREQ), .BY_AGE(1'b0)) u_rr_pick (
        .cand     (occ),
        .age_flat (age_flat),
        .ptr      (rr_ptr_q),
        .found    (rr_found),
        .win      (rr_win)
    );

    rot_picker #(.NREQ(NREQ), .BY_AGE(1'b1)) u_age_pick (
        .cand     (occ),
        .age_flat (age_flat),
        .ptr      (age_ptr_q),
        .found    (age_found),
        .win      (age_win)
    );

    function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] w);
        return (int'(w) == NREQ - 1) ? '0 : w + 1'b1;
    endfunction

    // Policy of the next grant and its candidate winner
    always_comb begin
        use_age = cfg_policy_mask[gcnt_q];
        found   = use_age ? age_found : rr_found;
        win     = use_age ? age_win : rr_win;
    end

    // Grant, hold until the tail, then advance the used pointer and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            gnt_q     <= '0;
            gnt_idx_q <= '0;
            by_age_q  <= 1'b0;
            gcnt_q    <= '0;
            rr_ptr_q  <= '0;
            age_ptr_q <= '0;
        end else if (busy_q) begin
            if (pkt_done) begin
                busy_q <= 1'b0;
                gnt_q  <= '0;
            end
        end else if (found) begin
            busy_q    <= 1'b1;
            gnt_q     <= NREQ'(1) << win;
            gnt_idx_q <= win;
            by_age_q  <= use_age;
            gcnt_q    <= gcnt_q + 1'b1;
            if (use_age) age_ptr_q <= step_ptr(win);
            else         rr_ptr_q  <= step_ptr(win);
        end
    end

    assign gnt_vec    = gnt_q;
    assign gnt_active = busy_q;
    assign gnt_by_age = busy_q & by_age_q;
    assign gnt_age    = busy_q ? age_flat[gnt_idx_q*AGE_W +: AGE_W] : '0;
endmodule

// File: rtl/arb_checker.sv
// Temporal properties of the output arbiter, bound onto every instance.
module arb_checker #(
    parameter int NREQ    = 28,
    parameter int TIMER_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NREQ-1:0]    req_vec,
    input logic               pkt_done,
    input logic [NREQ-1:0]    gnt_vec,
    input logic               gnt_active,
    input logic               age_tick,
    input logic [TIMER_W-1:0] cfg_timer_period
);
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec));

    assert_active_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_active == (gnt_vec != '0));

    assert_grant_was_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_active) |-> ((gnt_vec & $past(req_vec)) != '0));

    assert_hold_until_tail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_active && !pkt_done) |=> $stable(gnt_vec));

    assert_idle_after_tail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_active && pkt_done) |=> !gnt_active);

    assert_tick_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_tick && cfg_timer_period != '0) |=> !age_tick);
endmodule

bind age_output_arbiter arb_checker #(
    .NREQ    (NUM_SRC * NUM_VC),
    .TIMER_W (TIMER_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_vec          (req_vec),
    .pkt_done         (pkt_done),
    .gnt_vec          (gnt_vec),
    .gnt_active       (gnt_active),
    .age_tick         (age_tick),
    .cfg_timer_period (cfg_timer_period)
);

// File: tb/sim_age_output_arbiter.sv
`timescale 1ns/1ps
module sim_age_output_arbiter;
    localparam int NREQ = 28;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [63:0]       cfg_policy_mask = '0;
    logic [31:0]       cfg_timer_period = 32'd4;
    logic [7:0]        cfg_req_bias = '0;
    logic [7:0]        cfg_rsp_bias = '0;
    logic [NREQ-1:0]   req_vec = '0;
    logic [NREQ*8-1:0] req_age = '0;
    logic              pkt_done = 1'b0;
    logic [NREQ-1:0]   gnt_vec;
    logic              gnt_active;
    logic [7:0]        gnt_age;
    logic              gnt_by_age;
    logic              age_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit prev_active = 1'b0;

    typedef struct { int idx; int age; string tag; } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    age_output_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_policy_mask(cfg_policy_mask),
        .cfg_timer_period(cfg_timer_period), .cfg_req_bias(cfg_req_bias),
        .cfg_rsp_bias(cfg_rsp_bias), .req_vec(req_vec), .req_age(req_age),
        .pkt_done(pkt_done), .gnt_vec(gnt_vec), .gnt_active(gnt_active),
        .gnt_age(gnt_age), .gnt_by_age(gnt_by_age), .age_tick(age_tick)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int gidx();
        for (int i = 0; i < NREQ; i++) if (gnt_vec[i]) return i;
        return -1;
    endfunction

    task automatic request(input int idx, input int age);
        req_age[idx*8 +: 8] = 8'(age);
        req_vec[idx] = 1'b1;
    endtask

    task automatic expect_grant(input int idx, input int age, input string tag);
        exp_t e;
        e.idx = idx; e.age = age; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Serve n grants: hold each, check it is stable, then release with the tail
    task automatic serve(input int n, input int hold);
        for (int g = 0; g < n; g++) begin
            logic [NREQ-1:0] held;
            int idx;
            do @(negedge clk); while (!gnt_active);
            held = gnt_vec;
            idx = gidx();
            repeat (hold) @(negedge clk);
            chk(gnt_vec == held, "R1 grant held until tail", int'(gnt_vec), int'(held));
            pkt_done = 1'b1;
            if (idx >= 0) req_vec[idx] = 1'b0;
            @(negedge clk);
            pkt_done = 1'b0;
            chk(!gnt_active, "R1 released after tail", int'(gnt_active), 0);
        end
    endtask

    // Scoreboard monitor: compare each new grant with the next expected item
    always @(negedge clk) begin
        if (mon_en && gnt_active && !prev_active) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected grant", gidx(), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(gidx() == e.idx, {e.tag, " winner"}, gidx(), e.idx);
                chk(int'(gnt_age) == e.age, {e.tag, " age"}, int'(gnt_age), e.age);
            end
        end
        prev_active = gnt_active;
    end

    initial begin
        #(200000 * 20);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt [2];
        bit seen [2];
        int held0, held1, last_tick, spacing_done;

        repeat (3) @(negedge clk);
        chk(gnt_vec == '0, "R10 reset grant", int'(gnt_vec), 0);
        chk(!gnt_active, "R10 reset active", int'(gnt_active), 0);
        chk(gnt_age == 0, "R10 reset age", int'(gnt_age), 0);
        rst_n = 1'b1;

        // R9: timer period 4 -> ticks 5 cycles apart; blocked packet ages per tick
        @(negedge clk);
        request(0, 3);
        request(1, 3);
        cnt[0] = 0; cnt[1] = 0; seen[0] = 0; seen[1] = 0;
        held0 = 0; held1 = 0; last_tick = -1; spacing_done = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            pkt_done = 1'b0;
            for (int r = 0; r < 2; r++) begin
                if (!seen[r]) begin
                    if (gnt_vec[r]) begin
                        seen[r] = 1;
                        chk(int'(gnt_age) == 3 + cnt[r], "R9 age includes waiting ticks",
                            int'(gnt_age), 3 + cnt[r]);
                    end else if (age_tick) begin
                        cnt[r]++;
                    end
                end
            end
            if (age_tick) begin
                if (last_tick >= 0 && !spacing_done) begin
                    chk(c - last_tick == 5, "R9 tick spacing", c - last_tick, 5);
                    spacing_done = 1;
                end
                last_tick = c;
            end
            if (seen[0] && gnt_vec[0]) begin
                held0++;
                if (held0 == 12) begin pkt_done = 1'b1; req_vec[0] = 1'b0; end
            end
            if (seen[1] && gnt_vec[1]) begin
                held1++;
                if (held1 == 3) begin pkt_done = 1'b1; req_vec[1] = 1'b0; end
            end
        end
        pkt_done = 1'b0;
        chk(seen[0] && seen[1], "R9 both timer packets granted", int'(seen[1]), 1);
        chk(cnt[1] >= 2, "R9 blocked packet saw ticks", cnt[1], 2);
        cfg_timer_period = 32'd150000;
        repeat (12) @(negedge clk);
        mon_en = 1'b1;

        // R3: round-robin from pointer 2 (after grants 0 and 1)
        request(3, 11); request(10, 22); request(20, 33);
        expect_grant(3, 11, "R3 rr first");
        expect_grant(10, 22, "R3 rr second");
        expect_grant(20, 33, "R3 rr third");
        serve(3, 2);

        // R4: pure age, tie between 9 and 12 broken from age pointer 0
        cfg_policy_mask = '1;
        request(5, 40); request(9, 90); request(12, 90); request(27, 10);
        expect_grant(9, 90, "R4 age tie from ptr 0");
        expect_grant(12, 90, "R4 age next");
        expect_grant(5, 40, "R4 age third");
        expect_grant(27, 10, "R4 age last");
        serve(4, 1);

        // R4/R5: age pointer moved to 17; tie of 2,15,20 goes to 20, then wraps to 2
        request(16, 1);
        expect_grant(16, 1, "R5 age pointer step");
        serve(1, 1);
        request(2, 50); request(15, 50); request(20, 50);
        expect_grant(20, 50, "R4 tie from ptr 17");
        expect_grant(2, 50, "R4 tie wraps");
        expect_grant(15, 50, "R4 tie last");
        serve(3, 1);

        // R5: round-robin pointer still 21 after age grants
        cfg_policy_mask = '0;
        request(4, 7); request(22, 8);
        expect_grant(22, 8, "R5 rr pointer kept");
        expect_grant(4, 7, "R5 rr wraps");
        serve(2, 1);

        // R6: grants 15 and 17 by age, 16 by round-robin from pointer 5
        cfg_policy_mask = 64'h0000_0000_0002_8000;
        request(6, 5); request(1, 200); request(8, 100);
        expect_grant(1, 200, "R6 mask bit 15 age");
        expect_grant(6, 5, "R6 mask bit 16 rr");
        expect_grant(8, 100, "R6 mask bit 17 age");
        serve(3, 1);

        // R6: fill to grant 64 so the counter wraps onto mask bit 0
        cfg_policy_mask = 64'h1;
        for (int f = 18; f < 64; f++) begin
            request(0, 0);
            expect_grant(0, 0, "R6 filler rr");
            serve(1, 1);
        end
        request(3, 1); request(25, 99);
        expect_grant(25, 99, "R6 counter wrap uses bit 0");
        expect_grant(3, 1, "R6 bit 1 rr");
        serve(2, 1);

        // R7/R8: class biases and saturation
        cfg_policy_mask = '1;
        cfg_req_bias = 8'd7;
        cfg_rsp_bias = 8'd20;
        @(negedge clk);
        request(2, 250);   // source 0 vc 2: 250+20 saturates
        request(15, 10);   // source 3 vc 3: response bias
        request(9, 10);    // source 2 vc 1: request bias
        request(24, 0);    // source 6 vc 0: request bias
        expect_grant(2, 255, "R8 saturated arrival age");
        expect_grant(15, 30, "R7 response bias");
        expect_grant(9, 17, "R7 request bias vc1");
        expect_grant(24, 7, "R7 request bias vc0");
        serve(4, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all expected grants seen", exp_q.size(), 0);
        chk(!gnt_active, "R1 idle at end", int'(gnt_active), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule